// File: doc/BRIEF.md
# Embedded Core Timer Unit

This block provides the three timers an embedded processor core expects next to it. A down-counting interval timer is loaded through a reload write and, if allowed, reloads itself on every expiry. A fixed-period timer raises an event on each rising edge of one of four selectable time-base bits. A watchdog watches a second set of time-base bits and escalates over successive expiries: first it arms, then it raises an interrupt, and finally it requests a core, chip or system reset and records which one it asked for.

Software programs the unit through a 32-bit control word and reads events back through a 32-bit status word whose event bits are cleared by writing ones. Each interrupt line is the AND of its status bit and its enable bit in the control word. The free-running time base is supplied from outside, and the interval timer counts down once per clock.

Top module: `emb_timer_unit`

## Requirements
- R1: After reset, the control word, status word and interval count read zero, all three interrupt lines are low and the reset request is 0.
- R2: A control write stores bits 31:22 (31:30 watchdog period select, 29:28 watchdog reset kind, 27 watchdog interrupt enable, 26 interval timer enable, 25:24 fixed period select, 23 fixed interrupt enable, 22 auto-reload enable); bits 21:0 always read zero.
- R3: A rising edge of time-base bit FIX_TAP_LO + FIX_TAP_STEP*sel, where sel is control bits 25:24, sets status bit 26 one clock later; edges on other bits do not; irq_fixed equals status bit 26 AND control bit 23.
- R4: After a reload write of N >= 2 with control bit 26 set, the count reads N and drops by one per clock; on the Nth clock after the write status bit 27 is set, and irq_ivl equals status bit 27 AND control bit 26.
- R5: On expiry with control bit 22 set the count returns to N and the timer fires again every N clocks; with bit 22 clear the count stops at 0 and no further expiry occurs.
- R6: A reload value of 0 or 1, or control bit 26 clear, leaves the timer stopped: the count holds its value and status bit 27 is not set; clearing bit 26 while running halts the count.
- R7: On a watchdog expiry with status bits 31:30 at 00 or 01, bit 31 is set; at 10, bit 30 is set; irq_wdg equals status bit 30 AND control bit 27.
- R8: On a watchdog expiry with status bits 31:30 at 11, control bits 29:28 are copied into status bits 29:28 and rst_req shows that code for exactly one clock (0 none, 1 core, 2 chip, 3 system); bits 31:30 keep their value.
- R9: A status clear write clears every status bit whose mask bit is 1 and leaves others unchanged; an event in the same clock as its clear leaves the bit set; bits 25:0 always read zero.
- R10: The watchdog expires on rising edges of time-base bit WDG_TAP_LO + WDG_TAP_STEP*sel, with sel being control bits 31:30; edges on other bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbase | input | TB_W | Free-running time-base count |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_mask | input | 32 | Status bits to clear (1 = clear) |
| rld_we | input | 1 | Interval reload write strobe |
| rld_wdata | input | IVL_W | Interval reload value |
| ctl_q | output | 32 | Control word |
| sts_q | output | 32 | Status word |
| ivl_count | output | IVL_W | Current interval count |
| irq_fixed | output | 1 | Fixed-period interrupt |
| irq_ivl | output | 1 | Interval timer interrupt |
| irq_wdg | output | 1 | Watchdog interrupt |
| rst_req | output | 2 | Encoded reset request pulse |

## Verification
The bench builds the unit with a 16-bit time base and a 16-bit interval counter, and moves the taps down so that the fixed timer watches bits 1 to 4 and the watchdog bits 5 to 8. With those taps every expiry is produced by writing a single time-base value, so selected and unselected taps, the full three-step watchdog escalation for several reset kinds and the clear-versus-set collision can all be hit on an exact clock. The narrow counter keeps reload, auto-reload and halt sequences to a handful of cycles each.

// File: rtl/etu_pkg.sv
package etu_pkg;
   // control word field positions (software decodes these)
   localparam int C_WPER = 30;
   localparam int C_WRST = 28;
   localparam int C_WIE  = 27;
   localparam int C_IEN  = 26;
   localparam int C_FPER = 24;
   localparam int C_FIE  = 23;
   localparam int C_ARE  = 22;
   localparam logic [31:0] C_MASK = 32'hFFC0_0000;

   // status word field positions
   localparam int S_ARM   = 31;
   localparam int S_WIS   = 30;
   localparam int S_CAUSE = 28;
   localparam int S_IVL   = 27;
   localparam int S_FIX   = 26;
   localparam logic [31:0] S_MASK = 32'hFC00_0000;

   // number of selectable taps per timer and width of the selector
   localparam int NTAP = 4;
   localparam int TSEL_W = 2;

   typedef enum logic [1:0] {
      RST_NONE = 2'd0,
      RST_CORE = 2'd1,
      RST_CHIP = 2'd2,
      RST_SYS  = 2'd3
   } rst_kind_e;
endpackage

// File: rtl/etu_tap_edge.sv
module etu_tap_edge import etu_pkg::*; #(
   parameter int TB_W = 32,
   parameter int LO   = 9,
   parameter int STEP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TB_W-1:0]   tb,
   input  logic [TSEL_W-1:0] sel,
   output logic              fire
);
   localparam int TOP = LO + (NTAP - 1) * STEP;

   if (TOP >= TB_W || LO < 0 || STEP < 1) begin : g_bad_taps
      $error("etu_tap_edge: tap range does not fit in the time base");
   end

   logic [NTAP-1:0] taps;
   logic [NTAP-1:0] taps_q;
   logic            tb_unused;

   for (genvar k = 0; k < NTAP; k++) begin : g_tap
      assign taps[k] = tb[LO + k * STEP];
   end

   assign tb_unused = ^tb;

   // every tap keeps its own history so a period change cannot fake an edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) taps_q <= '0;
      else        taps_q <= taps;
   end

   assign fire = taps[sel] & ~taps_q[sel];
endmodule

// File: rtl/etu_ivl.sv
module etu_ivl #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         enable,
   input  logic         auto_rld,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] count,
   output logic         fire
);
   localparam logic [W-1:0] ONE = W'(1);

   if (W < 2) begin : g_bad_width
      $error("etu_ivl: counter width must be at least 2");
   end

   logic         run;
   logic [W-1:0] cnt;
   logic [W-1:0] rld;

   assign fire  = run & enable & (cnt == ONE);
   assign count = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         cnt <= '0;
         rld <= '0;
      end else if (ld) begin
         rld <= ld_val;
         cnt <= ld_val;
         run <= enable && (ld_val > ONE);
      end else if (!enable) begin
         run <= 1'b0;
      end else if (run) begin
         if (cnt == ONE) begin
            if (auto_rld) begin
               cnt <= rld;
            end else begin
               cnt <= '0;
               run <= 1'b0;
            end
         end else begin
            cnt <= cnt - ONE;
         end
      end
   end
endmodule

// File: rtl/etu_wdg.sv
module etu_wdg import etu_pkg::*; (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       expire,
   input  logic [1:0] stage,
   input  logic [1:0] rst_sel,
   output logic       set_arm,
   output logic       set_wis,
   output logic       take_rst,
   output logic [1:0] rst_req
);
   rst_kind_e req_q;

   always_comb begin
      set_arm  = 1'b0;
      set_wis  = 1'b0;
      take_rst = 1'b0;
      if (expire) begin
         unique case (stage)
            2'b00, 2'b01: set_arm  = 1'b1;
            2'b10:        set_wis  = 1'b1;
            2'b11:        take_rst = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        req_q <= RST_NONE;
      else if (take_rst) req_q <= rst_kind_e'(rst_sel);
      else               req_q <= RST_NONE;
   end

   assign rst_req = req_q;
endmodule

// File: rtl/emb_timer_unit.sv
module emb_timer_unit import etu_pkg::*; #(
   parameter int TB_W         = 32,
   parameter int IVL_W        = 32,
   parameter int FIX_TAP_LO   = 9,
   parameter int FIX_TAP_STEP = 4,
   parameter int WDG_TAP_LO   = 17,
   parameter int WDG_TAP_STEP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TB_W-1:0]  tbase,
   input  logic             ctl_we,
   input  logic [31:0]      ctl_wdata,
   input  logic             sts_clr_we,
   input  logic [31:0]      sts_clr_mask,
   input  logic             rld_we,
   input  logic [IVL_W-1:0] rld_wdata,
   output logic [31:0]      ctl_q,
   output logic [31:0]      sts_q,
   output logic [IVL_W-1:0] ivl_count,
   output logic             irq_fixed,
   output logic             irq_ivl,
   output logic             irq_wdg,
   output logic [1:0]       rst_req
);
   logic        fix_fire;
   logic        wdg_fire;
   logic        ivl_fire;
   logic        w_arm;
   logic        w_wis;
   logic        w_rst;
   logic [31:0] sts_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_we) ctl_q <= ctl_wdata & C_MASK;
   end

   etu_tap_edge #(
      .TB_W (TB_W),
      .LO   (FIX_TAP_LO),
      .STEP (FIX_TAP_STEP)
   ) u_fix_tap (
      .clk   (clk),
      .rst_n (rst_n),
      .tb    (tbase),
      .sel   (ctl_q[C_FPER +: TSEL_W]),
      .fire  (fix_fire)
   );

   etu_tap_edge #(
      .TB_W (TB_W),
      .LO   (WDG_TAP_LO),
      .STEP (WDG_TAP_STEP)
   ) u_wdg_tap (
      .clk   (clk),
      .rst_n (rst_n),
      .tb    (tbase),
      .sel   (ctl_q[C_WPER +: TSEL_W]),
      .fire  (wdg_fire)
   );

   etu_ivl #(
      .W (IVL_W)
   ) u_ivl (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (ctl_q[C_IEN]),
      .auto_rld (ctl_q[C_ARE]),
      .ld       (rld_we),
      .ld_val   (rld_wdata),
      .count    (ivl_count),
      .fire     (ivl_fire)
   );

   etu_wdg u_wdg (
      .clk      (clk),
      .rst_n    (rst_n),
      .expire   (wdg_fire),
      .stage    (sts_q[S_WIS +: 2]),
      .rst_sel  (ctl_q[C_WRST +: 2]),
      .set_arm  (w_arm),
      .set_wis  (w_wis),
      .take_rst (w_rst),
      .rst_req  (rst_req)
   );

   // clears first, hardware events after: an event never gets lost
   always_comb begin
      sts_nxt = sts_q;
      if (sts_clr_we) sts_nxt = sts_nxt & ~sts_clr_mask;
      if (fix_fire)   sts_nxt[S_FIX] = 1'b1;
      if (ivl_fire)   sts_nxt[S_IVL] = 1'b1;
      if (w_arm)      sts_nxt[S_ARM] = 1'b1;
      if (w_wis)      sts_nxt[S_WIS] = 1'b1;
      if (w_rst)      sts_nxt[S_CAUSE +: 2] = ctl_q[C_WRST +: 2];
      sts_nxt = sts_nxt & S_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q <= '0;
      else        sts_q <= sts_nxt;
   end

   assign irq_fixed = sts_q[S_FIX] & ctl_q[C_FIE];
   assign irq_ivl   = sts_q[S_IVL] & ctl_q[C_IEN];
   assign irq_wdg   = sts_q[S_WIS] & ctl_q[C_WIE];
endmodule

// File: rtl/etu_chk.sv
module etu_chk #(
   parameter int IVL_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [4:0]       sts_hi,
   input logic [1:0]       cause,
   input logic             ivl_en,
   input logic             rld_we,
   input logic [IVL_W-1:0] ivl_count,
   input logic [1:0]       rst_req
);
   // R8
   rst_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req != 2'b00) |-> ($past(sts_hi[4:3]) == 2'b11));

   // R8
   cause_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req != 2'b00) |-> (cause == rst_req));

   // R7
   wis_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_hi[3]) |-> ($past(sts_hi[4:3]) == 2'b10));

   // R4
   ivl_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_hi[0]) |-> ($past(ivl_count) == IVL_W'(1)));

   // R6
   ivl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ivl_en && !$past(ivl_en) && !$past(rld_we)) |-> $stable(ivl_count));
endmodule

bind emb_timer_unit etu_chk #(
   .IVL_W (IVL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sts_hi    (sts_q[31:27]),
   .cause     (sts_q[29:28]),
   .ivl_en    (ctl_q[26]),
   .rld_we    (rld_we),
   .ivl_count (ivl_count),
   .rst_req   (rst_req)
);

// File: tb/sim_emb_timer_unit.sv
`timescale 1ns/1ps
module sim_emb_timer_unit;
   localparam int TB_W  = 16;
   localparam int IVL_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [TB_W-1:0]  tbase = '0;
   logic             ctl_we = 1'b0;
   logic [31:0]      ctl_wdata = '0;
   logic             sts_clr_we = 1'b0;
   logic [31:0]      sts_clr_mask = '0;
   logic             rld_we = 1'b0;
   logic [IVL_W-1:0] rld_wdata = '0;
   logic [31:0]      ctl_q;
   logic [31:0]      sts_q;
   logic [IVL_W-1:0] ivl_count;
   logic             irq_fixed;
   logic             irq_ivl;
   logic             irq_wdg;
   logic [1:0]       rst_req;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   emb_timer_unit #(
      .TB_W         (TB_W),
      .IVL_W        (IVL_W),
      .FIX_TAP_LO   (1),
      .FIX_TAP_STEP (1),
      .WDG_TAP_LO   (5),
      .WDG_TAP_STEP (1)
   ) u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .tbase        (tbase),
      .ctl_we       (ctl_we),
      .ctl_wdata    (ctl_wdata),
      .sts_clr_we   (sts_clr_we),
      .sts_clr_mask (sts_clr_mask),
      .rld_we       (rld_we),
      .rld_wdata    (rld_wdata),
      .ctl_q        (ctl_q),
      .sts_q        (sts_q),
      .ivl_count    (ivl_count),
      .irq_fixed    (irq_fixed),
      .irq_ivl      (irq_ivl),
      .irq_wdg      (irq_wdg),
      .rst_req      (rst_req)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_ctl(input logic [31:0] v);
      ctl_we = 1'b1; ctl_wdata = v;
      tick();
      ctl_we = 1'b0;
   endtask

   task automatic clr_sts(input logic [31:0] m);
      sts_clr_we = 1'b1; sts_clr_mask = m;
      tick();
      sts_clr_we = 1'b0;
   endtask

   task automatic ld_ivl(input logic [IVL_W-1:0] v);
      rld_we = 1'b1; rld_wdata = v;
      tick();
      rld_we = 1'b0;
   endtask

   task automatic set_tb(input int v);
      tbase = TB_W'(v);
      tick();
   endtask

   task automatic t_reset();
      chk("R1", "ctl", ctl_q, 32'h0);
      chk("R1", "sts", sts_q, 32'h0);
      chk("R1", "count", 32'(ivl_count), 32'h0);
      chk("R1", "irqs", {29'h0, irq_fixed, irq_ivl, irq_wdg}, 32'h0);
      chk("R1", "rst_req", 32'(rst_req), 32'h0);
   endtask

   task automatic t_ctl();
      wr_ctl(32'hFFFF_FFFF);
      chk("R2", "masked write", ctl_q, 32'hFFC0_0000);
      wr_ctl(32'h0);
      chk("R2", "zero write", ctl_q, 32'h0);
   endtask

   task automatic t_fixed();
      // sel 2 -> time-base bit 3, interrupt enabled
      wr_ctl(32'h0280_0000);
      set_tb(4);
      chk("R3", "other tap ignored", 32'(sts_q[26]), 32'h0);
      set_tb(0);
      set_tb(8);
      chk("R3", "selected tap sets", 32'(sts_q[26]), 32'h1);
      chk("R3", "irq_fixed", 32'(irq_fixed), 32'h1);
      clr_sts(32'h0800_0000);
      chk("R9", "clear of other bit", 32'(sts_q[26]), 32'h1);
      clr_sts(32'h0400_0000);
      chk("R9", "clear by one", 32'(sts_q[26]), 32'h0);
      chk("R3", "irq_fixed after clear", 32'(irq_fixed), 32'h0);
      set_tb(0);
      sts_clr_we = 1'b1; sts_clr_mask = 32'h0400_0000;
      set_tb(8);
      sts_clr_we = 1'b0;
      chk("R9", "set wins over clear", 32'(sts_q[26]), 32'h1);
      clr_sts(32'hFFFF_FFFF);
      set_tb(0);
      wr_ctl(32'h0200_0000);
      set_tb(8);
      chk("R3", "status without enable", 32'(sts_q[26]), 32'h1);
      chk("R3", "irq masked", 32'(irq_fixed), 32'h0);
      chk("R9", "reserved bits", sts_q & 32'h03FF_FFFF, 32'h0);
      clr_sts(32'hFFFF_FFFF);
      set_tb(0);
   endtask

   task automatic t_ivl_single();
      wr_ctl(32'h0400_0000);
      ld_ivl(16'd5);
      chk("R4", "loaded count", 32'(ivl_count), 32'd5);
      repeat (4) tick();
      chk("R4", "count before expiry", 32'(ivl_count), 32'd1);
      chk("R4", "no early status", 32'(sts_q[27]), 32'h0);
      tick();
      chk("R4", "expiry status", 32'(sts_q[27]), 32'h1);
      chk("R4", "irq_ivl", 32'(irq_ivl), 32'h1);
      chk("R5", "stops at zero", 32'(ivl_count), 32'h0);
      clr_sts(32'h0800_0000);
      repeat (4) tick();
      chk("R5", "no second expiry", 32'(sts_q[27]), 32'h0);
      chk("R5", "stays zero", 32'(ivl_count), 32'h0);
   endtask

   task automatic t_ivl_auto();
      wr_ctl(32'h0440_0000);
      ld_ivl(16'd3);
      tick(); tick();
      chk("R5", "count at 1", 32'(ivl_count), 32'd1);
      tick();
      chk("R5", "first expiry", 32'(sts_q[27]), 32'h1);
      chk("R5", "reloaded", 32'(ivl_count), 32'd3);
      clr_sts(32'h0800_0000);
      chk("R5", "counting on", 32'(ivl_count), 32'd2);
      tick();
      chk("R5", "no status mid-period", 32'(sts_q[27]), 32'h0);
      tick();
      chk("R5", "second expiry", 32'(sts_q[27]), 32'h1);
      chk("R5", "reloaded again", 32'(ivl_count), 32'd3);
      clr_sts(32'hFFFF_FFFF);
   endtask

   task automatic t_ivl_stop();
      wr_ctl(32'h0440_0000);
      ld_ivl(16'd1);
      clr_sts(32'hFFFF_FFFF);
      repeat (4) tick();
      chk("R6", "reload 1 holds", 32'(ivl_count), 32'd1);
      chk("R6", "reload 1 no status", 32'(sts_q[27]), 32'h0);
      ld_ivl(16'd0);
      repeat (4) tick();
      chk("R6", "reload 0 holds", 32'(ivl_count), 32'd0);
      chk("R6", "reload 0 no status", 32'(sts_q[27]), 32'h0);
      wr_ctl(32'h0040_0000);
      ld_ivl(16'd4);
      repeat (6) tick();
      chk("R6", "disabled holds", 32'(ivl_count), 32'd4);
      chk("R6", "disabled no status", 32'(sts_q[27]), 32'h0);
      wr_ctl(32'h0400_0000);
      ld_ivl(16'd6);
      tick(); tick();
      chk("R6", "running before halt", 32'(ivl_count), 32'd4);
      wr_ctl(32'h0);
      repeat (5) tick();
      chk("R6", "halted count", 32'(ivl_count), 32'd3);
      chk("R6", "halted no status", 32'(sts_q[27]), 32'h0);
   endtask

   task automatic wdg_run(input logic [31:0] cfg, input logic [1:0] kind,
                          input logic irq_exp);
      clr_sts(32'hFFFF_FFFF);
      wr_ctl(cfg);
      // sel 1 -> time-base bit 6; bit 5 belongs to sel 0
      set_tb(32);
      chk("R10", "unselected tap ignored", 32'(sts_q[31:30]), 32'h0);
      set_tb(0);
      set_tb(64);
      chk("R7", "first stage arms", 32'(sts_q[31:30]), 32'h2);
      chk("R7", "no irq yet", 32'(irq_wdg), 32'h0);
      set_tb(0);
      set_tb(64);
      chk("R7", "second stage", 32'(sts_q[31:30]), 32'h3);
      chk("R7", "irq_wdg", 32'(irq_wdg), 32'(irq_exp));
      chk("R8", "no reset yet", 32'(rst_req), 32'h0);
      set_tb(0);
      set_tb(64);
      chk("R8", "reset request", 32'(rst_req), 32'(kind));
      chk("R8", "cause recorded", 32'(sts_q[29:28]), 32'(kind));
      chk("R8", "stage kept", 32'(sts_q[31:30]), 32'h3);
      set_tb(0);
      chk("R8", "one-clock pulse", 32'(rst_req), 32'h0);
   endtask

   task automatic t_wdg();
      wdg_run(32'h6800_0000, 2'd2, 1'b1);
      wdg_run(32'h7800_0000, 2'd3, 1'b1);
      wdg_run(32'h4000_0000, 2'd0, 1'b0);
      wdg_run(32'h5800_0000, 2'd1, 1'b1);
      // bit 30 alone (bit 31 cleared by software) re-arms
      clr_sts(32'h8000_0000);
      set_tb(64);
      chk("R7", "re-arm from 01", 32'(sts_q[31:30]), 32'h3);
      set_tb(0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_ctl();
      t_fixed();
      t_ivl_single();
      t_ivl_auto();
      t_ivl_stop();
      t_wdg();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule